// File: doc/BRIEF.md
# Bus-Activity Watchdog Timer

This block is the watchdog section of a microcontroller supervisor. The host does not restart the timer through a dedicated pin. It restarts it by running a short transaction on the two-wire serial bus that the supervisor already listens to. Both bus lines pass through a two-flop synchronizer and are watched on every clock, with no gating. A restart is recognised when three events occur in order: SDA falls, then SCL falls, then a stop condition (SDA rising while SCL stays high) closes the sequence. The restart clears the timeout counter and releases the watchdog output.

The timeout length is one of three preset terminal counts, each set by a parameter. A 2-bit interval code picks the count. The code sits in a retained register that models non-volatile storage. Code 00 means the watchdog is off. While the stored code is 00, one write can load a non-zero code. From then on the code is fixed. The power-cycle reset input returns the timer, the detector and the synchronizer to their idle state, but it leaves the stored code untouched.

Top module: `bus_watchdog`

## Requirements
- R1: While `rst` is high, on every rising clock edge `wdo` is forced low, the timeout count returns to zero and the pattern detector goes idle. The synchronizer flops load the idle bus level, which is high.
- R2: With interval code 01, 10 or 11 the output `wdo` rises exactly `TERM_SHORT`, `TERM_MID` or `TERM_LONG` clock edges after the last edge at which the count was cleared by reset, by a restart, or by the code still being 00.
- R3: While the stored interval code is 00 the watchdog is off: `wdo` stays low and the count is held at zero.
- R4: `rst` does not change the stored interval code; `ivl_code` reads the same value before and after a reset pulse.
- R5: A write (`cfg_we` high at a clock edge) loads `cfg_code` only while the stored code is 00. Once a non-zero code is stored, every later write is ignored. A write of 00 leaves the code at 00.
- R6: A restart is an SDA falling edge, followed later by an SCL falling edge, followed later by a stop condition (SDA rising while SCL is high, as seen after synchronization). The restart clears the count and drives `wdo` low.
- R7: A transaction with the SDA fall and the SCL fall but no stop condition does not restart the timer. The timer keeps counting and still times out.
- R8: A stop condition that arrives without an SCL falling edge after the SDA falling edge does not restart the timer. The detector returns to idle.
- R9: A pin change sampled at clock edge n reaches the pattern detector at edge n+2. A restart whose stop is sampled at edge n therefore gives `wdo` low after edge n+2.
- R10: Once asserted, `wdo` stays high until the next restart or reset; the count does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-cycle reset; the interval code survives it |
| scl_i | input | 1 | Serial bus clock line, asynchronous to `clk` |
| sda_i | input | 1 | Serial bus data line, asynchronous to `clk` |
| cfg_we | input | 1 | Write strobe for the retained interval code |
| cfg_code | input | 2 | Interval code to store: 00 off, 01 short, 10 medium, 11 long |
| wdo | output | 1 | Watchdog timeout, active high |
| ivl_code | output | 2 | Currently stored interval code |

## Verification
The bench builds three copies of the block with terminal counts cut to 20, 45 and 90. Each copy stores a different interval code, and all three watch the same bus wires. With these short counts, every interval can time out several times within a few thousand cycles. One sequence of bus stimulus therefore shows the exact timeout edge for all three codes, and shows that a transaction without a stop leaves every copy counting to expiry. A behavioural model with the same short counts predicts `wdo` and `ivl_code` on every clock, so the two-edge synchronizer delay and the one-edge release after a stop are checked cycle-exactly.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    // Retained interval code; OFF disables the watchdog.
    typedef enum logic [1:0] {
        IVL_OFF   = 2'b00,
        IVL_SHORT = 2'b01,
        IVL_MID   = 2'b10,
        IVL_LONG  = 2'b11
    } ivl_e;

    // Restart pattern tracker.
    typedef enum logic [1:0] {
        KD_IDLE    = 2'b00,
        KD_ARMED   = 2'b01,
        KD_PENDING = 2'b10
    } kd_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } bus_t;

    typedef struct packed {
        logic sda_fall;
        logic sda_rise;
        logic scl_fall;
        logic scl_high;
    } bus_ev_t;

    localparam bus_t BUS_IDLE = '{scl: 1'b1, sda: 1'b1};

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic bus_ev_t edges_of(input bus_t prev, input bus_t cur);
        bus_ev_t e;
        e.sda_fall = prev.sda & ~cur.sda;
        e.sda_rise = ~prev.sda & cur.sda;
        e.scl_fall = prev.scl & ~cur.scl;
        e.scl_high = prev.scl & cur.scl;
        return e;
    endfunction

endpackage

// File: rtl/bwd_sync.sv
module bwd_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], d[b]};
            end
        end

        assign q[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/bwd_kick_detect.sv
module bwd_kick_detect
    import bwd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  bus_t bus_s,
    output logic kick
);

    bus_t      prev_q;
    bus_ev_t   ev;
    kd_state_e state_q, state_d;
    logic      stop_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= BUS_IDLE;
        end else begin
            prev_q <= bus_s;
        end
    end

    always_comb begin
        ev        = edges_of(prev_q, bus_s);
        stop_seen = ev.sda_rise & ev.scl_high;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KD_IDLE: begin
                if (ev.sda_fall) state_d = KD_ARMED;
            end
            KD_ARMED: begin
                if (stop_seen)        state_d = KD_IDLE;
                else if (ev.scl_fall) state_d = KD_PENDING;
            end
            KD_PENDING: begin
                if (stop_seen) state_d = KD_IDLE;
            end
            default: state_d = KD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KD_IDLE;
        end else begin
            state_d_chk: state_q <= state_d;
        end
    end

    assign kick = (state_q == KD_PENDING) & stop_seen;

    AST_NO_SKIP_TO_PENDING: assert property (@(posedge clk) disable iff (rst)
        (state_q == KD_IDLE) |=> (state_q != KD_PENDING)); // R6

    AST_STOP_ENDS_PATTERN: assert property (@(posedge clk) disable iff (rst)
        (stop_seen && state_q != KD_IDLE) |=> (state_q == KD_IDLE)); // R8

endmodule

// File: rtl/bwd_cfg_keep.sv
module bwd_cfg_keep
    import bwd_pkg::*;
#(
    parameter ivl_e INIT = IVL_OFF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  ivl_e       wcode,
    output ivl_e       code
);

    // Retained storage: loaded once at manufacture, never touched by rst.
    ivl_e code_q = INIT;

    always_ff @(posedge clk) begin
        if (we && code_q == IVL_OFF) begin
            code_q <= wcode;
        end
    end

    assign code = code_q;

    AST_CODE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (code_q != IVL_OFF) |=> $stable(code_q)); // R5

    AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(code_q)); // R4

endmodule

// File: rtl/bwd_timer.sv
module bwd_timer
    import bwd_pkg::*;
#(
    parameter int unsigned TERM_SHORT = 1000,
    parameter int unsigned TERM_MID   = 4000,
    parameter int unsigned TERM_LONG  = 16000,
    parameter int unsigned CNT_W      = 14
) (
    input  logic clk,
    input  logic rst,
    input  ivl_e code,
    input  logic kick,
    output logic wdo
);

    typedef logic [CNT_W-1:0] cnt_t;

    cnt_t cnt_q;
    cnt_t term_c;
    cnt_t cnt_inc;
    logic wdo_q;

    always_comb begin
        unique case (code)
            IVL_SHORT: term_c = cnt_t'(TERM_SHORT);
            IVL_MID:   term_c = cnt_t'(TERM_MID);
            IVL_LONG:  term_c = cnt_t'(TERM_LONG);
            default:   term_c = '0;
        endcase
        cnt_inc = cnt_q + cnt_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || code == IVL_OFF || kick) begin
            cnt_q <= '0;
            wdo_q <= 1'b0;
        end else if (!wdo_q) begin
            cnt_q <= cnt_inc;
            wdo_q <= (cnt_inc == term_c);
        end
    end

    assign wdo = wdo_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (code != IVL_OFF) |-> (cnt_q <= term_c)); // R2

    AST_FIRE_AT_TERM: assert property (@(posedge clk) disable iff (rst)
        $rose(wdo_q) |-> (cnt_q == term_c)); // R2

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (code == IVL_OFF) |=> !wdo_q); // R3

    AST_KICK_RELEASES: assert property (@(posedge clk) disable iff (rst)
        kick |=> (!wdo_q && cnt_q == '0)); // R6

    AST_WDO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wdo_q && !kick && code != IVL_OFF) |=> wdo_q); // R10

endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
    import bwd_pkg::*;
#(
    parameter int unsigned TERM_SHORT  = 1000,
    parameter int unsigned TERM_MID    = 4000,
    parameter int unsigned TERM_LONG   = 16000,
    parameter int          SYNC_STAGES = 2,
    parameter ivl_e        CODE_INIT   = IVL_OFF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       cfg_we,
    input  logic [1:0] cfg_code,
    output logic       wdo,
    output logic [1:0] ivl_code
);

    localparam int unsigned TERM_MAX = max3(TERM_SHORT, TERM_MID, TERM_LONG);
    localparam int unsigned CNT_W    = $clog2(TERM_MAX + 1);

    bus_t bus_raw;
    bus_t bus_s;
    logic kick;
    ivl_e code;

    assign bus_raw = '{scl: scl_i, sda: sda_i};

    bwd_sync #(
        .W       (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BUS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_raw),
        .q   (bus_s)
    );

    bwd_kick_detect u_detect (
        .clk   (clk),
        .rst   (rst),
        .bus_s (bus_s),
        .kick  (kick)
    );

    bwd_cfg_keep #(
        .INIT (CODE_INIT)
    ) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wcode (ivl_e'(cfg_code)),
        .code  (code)
    );

    bwd_timer #(
        .TERM_SHORT (TERM_SHORT),
        .TERM_MID   (TERM_MID),
        .TERM_LONG  (TERM_LONG),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .code (code),
        .kick (kick),
        .wdo  (wdo)
    );

    assign ivl_code = code;

    AST_RST_CLEARS: assert property (@(posedge clk)
        rst |=> !wdo); // R1

endmodule

// File: tb/bus_watchdog_test.sv
module bus_watchdog_test;

    localparam int CLK_PERIOD = 10;
    localparam int T_S = 20;
    localparam int T_M = 45;
    localparam int T_L = 90;
    localparam int WATCH_LIMIT = 50000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic we  = 1'b0;
    logic [1:0] code_w [3];
    logic [2:0] wdo_v;
    logic [1:0] ivl_v [3];

    int total = 0;
    int bad = 0;
    int cyc = 0;
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_watchdog #(.TERM_SHORT(T_S), .TERM_MID(T_M), .TERM_LONG(T_L)) uut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .cfg_we(we),
        .cfg_code(code_w[0]), .wdo(wdo_v[0]), .ivl_code(ivl_v[0]));

    bus_watchdog #(.TERM_SHORT(T_S), .TERM_MID(T_M), .TERM_LONG(T_L)) uut_mid (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .cfg_we(we),
        .cfg_code(code_w[1]), .wdo(wdo_v[1]), .ivl_code(ivl_v[1]));

    bus_watchdog #(.TERM_SHORT(T_S), .TERM_MID(T_M), .TERM_LONG(T_L)) uut_long (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .cfg_we(we),
        .cfg_code(code_w[2]), .wdo(wdo_v[2]), .ivl_code(ivl_v[2]));

    // Behavioural reference model
    int h_scl [3];
    int h_sda [3];
    int m_phase [3];   // 0 idle, 1 saw sda fall, 2 saw scl fall after it
    int m_cnt [3];
    int m_wdo [3];
    int m_sel [3];

    function automatic int term_of(input int s);
        if (s == 1) return T_S;
        if (s == 2) return T_M;
        if (s == 3) return T_L;
        return 0;
    endfunction

    initial begin
        for (int i = 0; i < 3; i++) begin
            h_scl[i] = 1; h_sda[i] = 1;
            m_phase[i] = 0; m_cnt[i] = 0; m_wdo[i] = 0; m_sel[i] = 0;
        end
        code_w[0] = 2'b00; code_w[1] = 2'b00; code_w[2] = 2'b00;
    end

    always @(posedge clk) begin
        int c_scl, p_scl, c_sda, p_sda;
        bit stop, sfall, cfall;
        c_scl = h_scl[1]; p_scl = h_scl[2];
        c_sda = h_sda[1]; p_sda = h_sda[2];
        stop  = (p_sda == 0 && c_sda == 1 && p_scl == 1 && c_scl == 1);
        sfall = (p_sda == 1 && c_sda == 0);
        cfall = (p_scl == 1 && c_scl == 0);
        if (rst) begin
            for (int k = 0; k < 3; k++) begin
                h_scl[k] = 1; h_sda[k] = 1;
            end
            for (int i = 0; i < 3; i++) begin
                m_phase[i] = 0; m_cnt[i] = 0; m_wdo[i] = 0;
            end
        end else begin
            for (int i = 0; i < 3; i++) begin
                bit kicked;
                kicked = (m_phase[i] == 2) && stop;
                if (m_phase[i] == 0) begin
                    if (sfall) m_phase[i] = 1;
                end else if (stop) begin
                    m_phase[i] = 0;
                end else if (m_phase[i] == 1 && cfall) begin
                    m_phase[i] = 2;
                end
                if (m_sel[i] == 0 || kicked) begin
                    m_cnt[i] = 0; m_wdo[i] = 0;
                end else if (m_wdo[i] == 0) begin
                    m_cnt[i]++;
                    if (m_cnt[i] == term_of(m_sel[i])) m_wdo[i] = 1;
                end
            end
            h_scl[2] = h_scl[1]; h_scl[1] = h_scl[0]; h_scl[0] = int'(scl);
            h_sda[2] = h_sda[1]; h_sda[1] = h_sda[0]; h_sda[0] = int'(sda);
        end
        if (we) begin
            for (int i = 0; i < 3; i++) begin
                if (m_sel[i] == 0) m_sel[i] = int'(code_w[i]);
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d",
                     req, what, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        for (int i = 0; i < 3; i++) begin
            check(wdo_v[i] === 1'(m_wdo[i]), tag, $sformatf("wdo[%0d]", i),
                  int'(wdo_v[i]), m_wdo[i]);
            check(ivl_v[i] === 2'(m_sel[i]), tag, $sformatf("ivl_code[%0d]", i),
                  int'(ivl_v[i]), m_sel[i]);
        end
    end

    task automatic report_and_end();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCH_LIMIT) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WATCH_LIMIT);
            report_and_end();
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // SDA fall, SCL fall, data low, SCL high, then SDA rise (stop)
    task automatic full_restart();
        sda = 1'b0; wait_n(4);
        scl = 1'b0; wait_n(4);
        scl = 1'b1; wait_n(4);
        sda = 1'b1; wait_n(4);
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        wait_n(3);
        for (int i = 0; i < 3; i++) begin
            check(wdo_v[i] == 1'b0, "R1", "wdo in reset", int'(wdo_v[i]), 0);
        end
        @(negedge clk); rst = 1'b0;

        // R3: off code never times out
        tag = "R3";
        wait_n(2 * T_L);
        check(wdo_v == 3'b000, "R3", "wdo with code 00", int'(wdo_v), 0);

        // R5: write of 00 keeps 00
        tag = "R5";
        we = 1'b1; wait_n(1); we = 1'b0; wait_n(1);
        check(ivl_v[0] == 2'b00, "R5", "code after 00 write", int'(ivl_v[0]), 0);

        // R5/R2: load three codes, then let each time out
        code_w[0] = 2'b01; code_w[1] = 2'b10; code_w[2] = 2'b11;
        we = 1'b1; wait_n(1); we = 1'b0;
        tag = "R2";
        wait_n(T_S - 1);
        check(wdo_v[0] == 1'b0, "R2", "short one edge early", int'(wdo_v[0]), 0);
        wait_n(1);
        check(wdo_v[0] == 1'b1, "R2", "short at terminal", int'(wdo_v[0]), 1);
        tag = "R10";
        wait_n(T_L);
        check(wdo_v == 3'b111, "R10", "all held high", int'(wdo_v), 7);

        // R6/R9: full restart releases every copy
        tag = "R6_R9";
        full_restart();
        check(wdo_v == 3'b000, "R6", "released after stop", int'(wdo_v), 0);
        wait_n(T_L + 5);

        // R7: SDA fall and SCL fall, no stop; return to idle without a stop
        tag = "R7";
        full_restart();
        sda = 1'b0; wait_n(4);
        scl = 1'b0; wait_n(T_L + 5);
        check(wdo_v == 3'b111, "R7", "timeout without stop", int'(wdo_v), 7);
        sda = 1'b1; wait_n(4);
        scl = 1'b1; wait_n(4);
        check(wdo_v == 3'b111, "R7", "still high, no stop", int'(wdo_v), 7);

        // R4: power cycle keeps codes
        tag = "R4";
        rst = 1'b1; wait_n(2); rst = 1'b0; wait_n(1);
        check(ivl_v[0] == 2'b01 && ivl_v[1] == 2'b10 && ivl_v[2] == 2'b11, "R4",
              "codes after reset", int'({ivl_v[0], ivl_v[1], ivl_v[2]}), 6'b011011);
        check(wdo_v == 3'b000, "R1", "wdo after reset pulse", int'(wdo_v), 0);

        // R8: SCL falls before SDA, then stop: no restart
        tag = "R8";
        wait_n(T_S - 12);
        scl = 1'b0; wait_n(2);
        sda = 1'b0; wait_n(2);
        scl = 1'b1; wait_n(2);
        sda = 1'b1; wait_n(8);
        check(wdo_v[0] == 1'b1, "R8", "short times out despite lone stop",
              int'(wdo_v[0]), 1);

        // R5: later writes are ignored
        tag = "R5";
        code_w[0] = 2'b11; code_w[1] = 2'b01; code_w[2] = 2'b00;
        we = 1'b1; wait_n(1); we = 1'b0; wait_n(1);
        check(ivl_v[0] == 2'b01, "R5", "locked code short", int'(ivl_v[0]), 1);
        check(ivl_v[2] == 2'b11, "R5", "locked code long", int'(ivl_v[2]), 3);

        // R2: second round of timeouts after a restart
        tag = "R2";
        wait_n(T_L);
        full_restart();
        wait_n(T_L + 10);
        check(wdo_v == 3'b111, "R2", "second timeout round", int'(wdo_v), 7);

        report_and_end();
    end

endmodule